// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA

This block moves received Ethernet frames from a MAC byte stream into host memory. The host places a chain of 32-byte descriptors in memory. Each descriptor names a buffer, gives its size and links to the next descriptor. The host arms the engine by writing the address of the first descriptor and then setting the valid bit in the pointer-high register. The engine reads the descriptor and checks that the host has handed it over. It packs the incoming bytes little-endian into 32-bit words in the buffer. At the end of the frame it writes back the stored byte count and a status word, and then follows the link.

The engine stops when it reaches the end of the chain or a descriptor it does not own. In either case it raises a sticky end-of-queue flag, which the host clears by writing a one to it. All memory traffic goes through a single 32-bit master port. That port has one request outstanding at a time, and each request is held until the memory acknowledges it. The MAC stream cannot be stalled. If the memory is too slow to accept a packed word before the next word completes, the frame is marked as overrun.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset every host register reads as zero and `mem_req` is low. The register selects are 0 for control, 1 for status, 2 for pointer-low and 3 for pointer-high.
- R2: Writing 1 to bit 31 of pointer-high arms a stopped engine at the pointer-low address, and bit 31 of pointer-high then reads as 1. No memory access happens until both control bit 15 (go) and control bit 0 (queue 0 enable) are set.
- R3: Bit 15 of descriptor word 5 is the ownership bit. If a fetched descriptor has this bit clear, the engine stops and sets status bit 0. Incoming bytes are then dropped, and memory is left untouched, until the engine is re-armed.
- R4: Frame byte k is stored at buffer address (word 0) + k, in byte lane k mod 4 of its word. A final partial word enables only the lanes that hold received bytes.
- R5: At the end of a frame the engine writes two words. First, bits 15:0 of word 4 receive the stored byte count, and bits 31:16 of word 4 are left unchanged. Then word 5 is written with bits 31:16 kept, bit 15 cleared, bits 1 and 0 set, and error bits placed at 4, 8, 9, 11 and 12.
- R6: Bytes beyond the buffer size (word 5 bits 31:16) are dropped. The frame then reports bit 11 and bit 8, and the count equals the buffer size.
- R7: A frame shorter than MIN_LEN (default 64) bytes reports bit 4 and bit 8. A frame with `rx_err` on any of its bytes reports bit 12 and bit 8.
- R8: If a packed word completes while the previous memory write is still unacknowledged, the frame reports bit 9 and bit 8. That word and all later bytes of the frame are dropped, and the count excludes them.
- R9: After write-back the engine fetches from the address in word 2, unless bit 31 of word 3 is set. In that case it stops and sets status bit 0.
- R10: Status bit 0 stays set until the host writes 1 to it. Writing 0 leaves it set, and a set from the engine in the same cycle wins over the clear.
- R11: Once raised, `mem_req` stays high, with address, data, byte enables and direction stable, until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Host register select |
| reg_wr | input | 1 | Host register write strobe |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Frame error (CRC) flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes this cycle |

## Verification
The hardest case to reach is overrun. It needs a memory write to be still pending at the exact moment the second packed word of a frame completes, because the stream has no back-pressure. The bench gets there by giving its memory model an acknowledge latency of several cycles and then streaming one byte per cycle. It then checks that only the first four bytes land in the buffer, that the lost word's location keeps its old pattern, and that the count and status report exactly that loss.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [3:0] {
    S_STOP, S_ARMED, S_FETCH, S_CHECK, S_WAIT,
    S_RECV, S_FLUSH, S_WB_LEN, S_WB_STAT, S_NEXT
  } rxd_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_QLO  = 2'd2;
  localparam logic [1:0] SEL_QHI  = 2'd3;

  localparam int OFF_BUF  = 0;
  localparam int OFF_NXLO = 8;
  localparam int OFF_NXHI = 12;
  localparam int OFF_CNT  = 16;
  localparam int OFF_CFG  = 20;

  localparam int CTL_GO = 15;
  localparam int OWN_BIT = 15;
  localparam int LAST_BIT = 31;

  function automatic logic [5:0] fetch_off(input logic [1:0] idx);
    case (idx)
      2'd0:    fetch_off = 6'(OFF_BUF);
      2'd1:    fetch_off = 6'(OFF_NXLO);
      2'd2:    fetch_off = 6'(OFF_NXHI);
      default: fetch_off = 6'(OFF_CFG);
    endcase
  endfunction
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs #(
  parameter int DW = 32,
  parameter int NQ = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eoq_set,
  input  logic          running,
  output logic          go,
  output logic [NQ-1:0] qen,
  output logic [DW-1:0] qlo,
  output logic          arm,
  output logic          eoq
);
  import rxd_pkg::*;

  logic          go_q, go_n;
  logic [NQ-1:0] qen_q, qen_n;
  logic [DW-1:0] qlo_q, qlo_n;
  logic          eoq_q, eoq_n;

  always_comb begin
    go_n  = go_q;
    qen_n = qen_q;
    qlo_n = qlo_q;
    eoq_n = eoq_q;
    if (reg_wr && reg_addr == SEL_CTRL) begin
      go_n  = reg_wdata[CTL_GO];
      qen_n = reg_wdata[NQ-1:0];
    end
    if (reg_wr && reg_addr == SEL_QLO) qlo_n = reg_wdata;
    if (reg_wr && reg_addr == SEL_STAT && reg_wdata[0]) eoq_n = 1'b0;
    if (eoq_set) eoq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      qen_q <= '0;
      qlo_q <= '0;
      eoq_q <= 1'b0;
    end else begin
      go_q  <= go_n;
      qen_q <= qen_n;
      qlo_q <= qlo_n;
      eoq_q <= eoq_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTRL: begin
        reg_rdata[CTL_GO]  = go_q;
        reg_rdata[NQ-1:0] = qen_q;
      end
      SEL_STAT: reg_rdata[0] = eoq_q;
      SEL_QLO:  reg_rdata = qlo_q;
      default:  reg_rdata[DW-1] = running;
    endcase
  end

  assign arm = reg_wr && (reg_addr == SEL_QHI) && reg_wdata[DW-1];
  assign go  = go_q;
  assign qen = qen_q;
  assign qlo = qlo_q;
  assign eoq = eoq_q;
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          flush,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [NB-1:0] out_be
);
  logic [LW-1:0] lane_q, lane_n;
  logic [DW-1:0] data_q, data_n, data_ins;
  logic [NB-1:0] be_q, be_n, be_ins;

  always_comb begin
    data_ins = data_q;
    be_ins   = be_q;
    for (int i = 0; i < NB; i++) begin
      if (LW'(i) == lane_q) begin
        data_ins[8*i +: 8] = din;
        be_ins[i]          = 1'b1;
      end
    end
  end

  always_comb begin
    lane_n    = lane_q;
    data_n    = data_q;
    be_n      = be_q;
    out_valid = 1'b0;
    out_data  = data_q;
    out_be    = be_q;
    if (clr) begin
      lane_n = '0;
      data_n = '0;
      be_n   = '0;
    end else if (push) begin
      if (lane_q == LW'(NB - 1)) begin
        out_valid = 1'b1;
        out_data  = data_ins;
        out_be    = be_ins;
        lane_n    = '0;
        data_n    = '0;
        be_n      = '0;
      end else begin
        lane_n = lane_q + 1'b1;
        data_n = data_ins;
        be_n   = be_ins;
      end
    end else if (flush) begin
      out_valid = |be_q;
      lane_n    = '0;
      data_n    = '0;
      be_n      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      lane_q <= lane_n;
      data_q <= data_n;
      be_q   <= be_n;
    end
  end
endmodule

// File: rtl/rxd_mport.sv
module rxd_mport #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] be,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [NB-1:0] mem_be,
  input  logic          mem_ack
);
  logic          req_q, req_n;
  logic          we_q, we_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] wd_q, wd_n;
  logic [NB-1:0] be_q, be_n;
  logic          load;

  assign load = issue && !req_q;

  always_comb begin
    req_n  = req_q;
    we_n   = we_q;
    addr_n = addr_q;
    wd_n   = wd_q;
    be_n   = be_q;
    if (load) begin
      req_n  = 1'b1;
      we_n   = we;
      addr_n = addr;
      wd_n   = we ? wdata : '0;
      be_n   = we ? be : '0;
    end else if (req_q && mem_ack) begin
      req_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      be_q   <= '0;
    end else begin
      req_q  <= req_n;
      we_q   <= we_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
      be_q   <= be_n;
    end
  end

  assign busy      = req_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign mem_be    = be_q;
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int NQ      = 4,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 64,
  localparam int NB     = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [NB-1:0] mem_be,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  import rxd_pkg::*;

  rxd_state_e     state_q, state_n;
  logic [AW-1:0]  cur_q, cur_n, buf_q, buf_n, nxt_q, nxt_n;
  logic           last_q, last_n, own_q, own_n;
  logic [CNT_W-1:0] size_q, size_n, stored_q, stored_n, total_q, total_n, woff_q, woff_n;
  logic [1:0]     fidx_q, fidx_n;
  logic           crc_q, crc_n, max_q, max_n, ovr_q, ovr_n, disc_q, disc_n;

  logic           go, arm, eoq, eoq_set, en_ok, running;
  logic [NQ-1:0]  qen;
  logic [AW-1:0]  qlo;
  logic           busy, mp_issue, mp_we;
  logic [AW-1:0]  mp_addr;
  logic [DW-1:0]  mp_wdata;
  logic [NB-1:0]  mp_be;
  logic           byte_acc, store_ok, pk_flush, pk_clr, pk_valid;
  logic [DW-1:0]  pk_data;
  logic [NB-1:0]  pk_be;
  logic           short_f, bad_f;
  logic [DW-1:0]  stat_word;

  assign en_ok   = go && qen[0];
  assign running = (state_q != S_STOP);

  rxd_regs #(.DW(DW), .NQ(NQ)) u_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .eoq_set, .running, .go, .qen, .qlo, .arm, .eoq
  );

  rxd_packer #(.DW(DW)) u_pack (
    .clk, .rst_n, .clr(pk_clr), .push(store_ok), .din(rx_data),
    .flush(pk_flush), .out_valid(pk_valid), .out_data(pk_data), .out_be(pk_be)
  );

  rxd_mport #(.AW(AW), .DW(DW)) u_mport (
    .clk, .rst_n, .issue(mp_issue), .we(mp_we), .addr(mp_addr),
    .wdata(mp_wdata), .be(mp_be), .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_be, .mem_ack
  );

  assign byte_acc = rx_valid &&
                    ((state_q == S_RECV) || (state_q == S_WAIT && rx_sof && en_ok));
  assign store_ok = byte_acc && !disc_q && (stored_q < size_q);
  assign pk_flush = (state_q == S_FLUSH) && !busy;
  assign pk_clr   = (state_q == S_CHECK);

  assign short_f = (total_q < CNT_W'(MIN_LEN));
  assign bad_f   = short_f | crc_q | max_q | ovr_q;

  always_comb begin
    stat_word = '0;
    stat_word[DW-1:16] = size_q;
    stat_word[12] = crc_q;
    stat_word[11] = max_q;
    stat_word[9]  = ovr_q;
    stat_word[8]  = bad_f;
    stat_word[4]  = short_f;
    stat_word[1]  = 1'b1;
    stat_word[0]  = 1'b1;
  end

  always_comb begin
    state_n  = state_q;
    cur_n    = cur_q;
    buf_n    = buf_q;
    nxt_n    = nxt_q;
    last_n   = last_q;
    own_n    = own_q;
    size_n   = size_q;
    fidx_n   = fidx_q;
    stored_n = stored_q;
    total_n  = total_q;
    woff_n   = woff_q;
    crc_n    = crc_q;
    max_n    = max_q;
    ovr_n    = ovr_q;
    disc_n   = disc_q;
    eoq_set  = 1'b0;
    mp_issue = 1'b0;
    mp_we    = 1'b0;
    mp_addr  = '0;
    mp_wdata = '0;
    mp_be    = '0;

    case (state_q)
      S_STOP: if (arm) begin
        cur_n   = qlo;
        state_n = S_ARMED;
      end
      S_ARMED: if (en_ok) begin
        fidx_n  = '0;
        state_n = S_FETCH;
      end
      S_FETCH: begin
        mp_addr  = cur_q + AW'(fetch_off(fidx_q));
        mp_issue = !busy;
        if (mem_ack) begin
          case (fidx_q)
            2'd0: buf_n = mem_rdata;
            2'd1: nxt_n = mem_rdata;
            2'd2: last_n = mem_rdata[LAST_BIT];
            default: begin
              size_n = mem_rdata[DW-1:16];
              own_n  = mem_rdata[OWN_BIT];
            end
          endcase
          fidx_n = fidx_q + 1'b1;
          if (fidx_q == 2'd3) state_n = S_CHECK;
        end
      end
      S_CHECK: begin
        stored_n = '0;
        total_n  = '0;
        woff_n   = '0;
        crc_n    = 1'b0;
        max_n    = 1'b0;
        ovr_n    = 1'b0;
        disc_n   = 1'b0;
        if (!own_q) begin
          eoq_set = 1'b1;
          state_n = S_STOP;
        end else begin
          state_n = S_WAIT;
        end
      end
      S_WAIT: if (byte_acc) state_n = rx_eof ? S_FLUSH : S_RECV;
      S_RECV: if (byte_acc && rx_eof) state_n = S_FLUSH;
      S_FLUSH: if (!busy) state_n = S_WB_LEN;
      S_WB_LEN: if (!busy) begin
        mp_issue = 1'b1;
        mp_we    = 1'b1;
        mp_addr  = cur_q + AW'(OFF_CNT);
        mp_wdata = DW'(stored_q);
        mp_be    = NB'(2'b11);
        state_n  = S_WB_STAT;
      end
      S_WB_STAT: if (!busy) begin
        mp_issue = 1'b1;
        mp_we    = 1'b1;
        mp_addr  = cur_q + AW'(OFF_CFG);
        mp_wdata = stat_word;
        mp_be    = '1;
        state_n  = S_NEXT;
      end
      S_NEXT: if (!busy) begin
        if (last_q) begin
          eoq_set = 1'b1;
          state_n = S_STOP;
        end else begin
          cur_n   = nxt_q;
          fidx_n  = '0;
          state_n = S_FETCH;
        end
      end
      default: state_n = S_STOP;
    endcase

    if (byte_acc) begin
      crc_n = crc_q | rx_err;
      if (total_q != '1) total_n = total_q + 1'b1;
      if (store_ok) begin
        stored_n = stored_q + 1'b1;
      end else if (!disc_q) begin
        max_n  = 1'b1;
        disc_n = 1'b1;
      end
    end

    if (pk_valid) begin
      if (busy) begin
        ovr_n    = 1'b1;
        disc_n   = 1'b1;
        stored_n = stored_q - CNT_W'(NB - 1);
      end else begin
        mp_issue = 1'b1;
        mp_we    = 1'b1;
        mp_addr  = buf_q + AW'({woff_q, 2'b00});
        mp_wdata = pk_data;
        mp_be    = pk_be;
        woff_n   = woff_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_STOP;
      cur_q    <= '0;
      buf_q    <= '0;
      nxt_q    <= '0;
      last_q   <= 1'b0;
      own_q    <= 1'b0;
      size_q   <= '0;
      fidx_q   <= '0;
      stored_q <= '0;
      total_q  <= '0;
      woff_q   <= '0;
      crc_q    <= 1'b0;
      max_q    <= 1'b0;
      ovr_q    <= 1'b0;
      disc_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      cur_q    <= cur_n;
      buf_q    <= buf_n;
      nxt_q    <= nxt_n;
      last_q   <= last_n;
      own_q    <= own_n;
      size_q   <= size_n;
      fidx_q   <= fidx_n;
      stored_q <= stored_n;
      total_q  <= total_n;
      woff_q   <= woff_n;
      crc_q    <= crc_n;
      max_q    <= max_n;
      ovr_q    <= ovr_n;
      disc_q   <= disc_n;
    end
  end
endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_req,
  input logic                mem_ack,
  input logic                mem_we,
  input logic [AW-1:0]       mem_addr,
  input logic [DW-1:0]       mem_wdata,
  input logic [DW/8-1:0]     mem_be,
  input logic [1:0]          reg_addr,
  input logic                reg_wr,
  input logic [DW-1:0]       reg_wdata,
  input logic                eoq,
  input rxd_pkg::rxd_state_e st,
  input logic                owner,
  input logic                go_ok,
  input logic [CNT_W-1:0]    stored_cnt,
  input logic [CNT_W-1:0]    buf_size,
  input logic [AW-1:0]       desc_addr
);
  import rxd_pkg::*;

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be)));

  p_eoq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoq && !(reg_wr && reg_addr == SEL_STAT && reg_wdata[0])) |=> eoq);

  p_unowned_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && !owner) |=> (st == S_STOP && eoq));

  p_armed_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && !go_ok) |=> (st == S_ARMED && !mem_req));

  p_fill_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECV) |-> (stored_cnt <= buf_size));

  p_release_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NEXT && mem_req) |-> (mem_we && !mem_wdata[OWN_BIT] && mem_wdata[1:0] == 2'b11
                                   && mem_addr == desc_addr + AW'(OFF_CFG)));
endmodule

bind rx_desc_dma rxd_dma_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .eoq(eoq),
  .st(state_q), .owner(own_q), .go_ok(en_ok), .stored_cnt(stored_q),
  .buf_size(size_q), .desc_addr(cur_q)
);

// File: tb/test_rx_desc_dma.sv
module test_rx_desc_dma;
  logic        clk, rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_sof, rx_eof, rx_err;
  logic [7:0]  rx_data;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  int checks = 0;
  int fails = 0;
  int dly = 0;
  int acks = 0;
  int wcnt = 0;
  logic [31:0] mem [0:1023];

  rx_desc_dma i_rx_desc_dma (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .rx_valid, .rx_data, .rx_sof, .rx_eof, .rx_err,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_be, .mem_rdata, .mem_ack
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wcnt >= dly) begin
        wcnt <= 0;
        mem_ack <= 1'b1;
        acks <= acks + 1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[11:2]];
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 7) & 8'hFF);
  endfunction

  function automatic logic [7:0] mbyte(input int addr);
    return mem[addr >> 2][8*(addr % 4) +: 8];
  endfunction

  task automatic send_frame(input int len, input int seed, input bit err);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, k);
      rx_sof = (k == 0); rx_eof = (k == len - 1); rx_err = err && (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] bufa, input logic [31:0] nxt,
                          input logic [31:0] nhi, input logic [31:0] cnt, input logic [31:0] cfg);
    mem[(a >> 2) + 0] = bufa; mem[(a >> 2) + 1] = 32'h0;
    mem[(a >> 2) + 2] = nxt;  mem[(a >> 2) + 3] = nhi;
    mem[(a >> 2) + 4] = cnt;  mem[(a >> 2) + 5] = cfg;
    mem[(a >> 2) + 6] = 32'h0; mem[(a >> 2) + 7] = 32'h0;
  endtask

  function automatic bit frame_ok(input int bufa, input int n, input int seed);
    for (int k = 0; k < n; k++)
      if (mbyte(bufa + k) != pat(seed, k)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v);
      chk(v == 32'h0, "R1 register reset value", v, 32'h0);
    end
    chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'h0);
  endtask

  task automatic t_gating();
    int a0;
    logic [31:0] v;
    put_desc(32'h100, 32'h400, 32'h120, 32'h0, 32'hABCD0000, 32'h01008000);
    put_desc(32'h120, 32'h800, 32'h0, 32'h80000000, 32'h0, 32'h01008000);
    reg_write(2'd2, 32'h100);
    reg_write(2'd3, 32'h80000000);
    a0 = acks;
    wait_cyc(40);
    chk(acks == a0, "R2 no access with go clear", 32'(acks - a0), 32'h0);
    reg_read(2'd3, v);
    chk(v[31] == 1'b1, "R2 armed readback", v, 32'h80000000);
    reg_write(2'd0, 32'h00008000);
    wait_cyc(40);
    chk(acks == a0, "R2 no access with queue disabled", 32'(acks - a0), 32'h0);
    reg_write(2'd0, 32'h00008001);
    wait_cyc(40);
    chk(acks - a0 == 4, "R2 descriptor fetched once enabled", 32'(acks - a0), 32'h4);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    send_frame(70, 1, 1'b0);
    wait_cyc(40);
    chk(frame_ok(32'h400, 70, 1), "R4 buffer contents little-endian", 0, 1);
    chk(mbyte(32'h400 + 70) == 8'hA5 && mbyte(32'h400 + 71) == 8'hA5,
        "R4 partial word lanes untouched", 32'(mbyte(32'h400 + 70)), 32'hA5);
    chk(mem[(32'h100 >> 2) + 4] == 32'hABCD0046, "R5 count word",
        mem[(32'h100 >> 2) + 4], 32'hABCD0046);
    chk(mem[(32'h100 >> 2) + 5] == 32'h01000003, "R5 status word",
        mem[(32'h100 >> 2) + 5], 32'h01000003);
    reg_read(2'd1, v);
    chk(v[0] == 1'b0, "R9 no end-of-queue mid chain", v, 32'h0);
  endtask

  task automatic t_chain_short();
    logic [31:0] v;
    send_frame(40, 2, 1'b0);
    wait_cyc(40);
    chk(frame_ok(32'h800, 40, 2), "R9 second frame in linked descriptor", 0, 1);
    chk(mem[(32'h120 >> 2) + 4] == 32'h00000028, "R5 count of short frame",
        mem[(32'h120 >> 2) + 4], 32'h28);
    chk(mem[(32'h120 >> 2) + 5] == 32'h01000113, "R7 short frame status",
        mem[(32'h120 >> 2) + 5], 32'h01000113);
    reg_read(2'd1, v);
    chk(v[0] == 1'b1, "R9 end-of-queue at last descriptor", v, 32'h1);
    reg_read(2'd3, v);
    chk(v[31] == 1'b0, "R9 engine stopped", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, v);
    chk(v[0] == 1'b1, "R10 write of zero keeps flag", v, 32'h1);
    reg_write(2'd1, 32'h1);
    reg_read(2'd1, v);
    chk(v[0] == 1'b0, "R10 write of one clears flag", v, 32'h0);
  endtask

  task automatic t_unowned_trunc();
    logic [31:0] v;
    put_desc(32'h140, 32'hC00, 32'h0, 32'h80000000, 32'h0, 32'h00100000);
    reg_write(2'd2, 32'h140);
    reg_write(2'd3, 32'h80000000);
    wait_cyc(40);
    reg_read(2'd1, v);
    chk(v[0] == 1'b1, "R3 unowned descriptor raises end-of-queue", v, 32'h1);
    reg_read(2'd3, v);
    chk(v[31] == 1'b0, "R3 engine stopped on unowned", v, 32'h0);
    send_frame(20, 3, 1'b0);
    wait_cyc(30);
    chk(mem[32'hC00 >> 2] == 32'hA5A5A5A5, "R3 bytes dropped while stopped",
        mem[32'hC00 >> 2], 32'hA5A5A5A5);
    chk(mem[(32'h140 >> 2) + 5] == 32'h00100000, "R3 descriptor not written",
        mem[(32'h140 >> 2) + 5], 32'h00100000);
    reg_write(2'd1, 32'h1);
    mem[(32'h140 >> 2) + 5] = 32'h00108000;
    reg_write(2'd3, 32'h80000000);
    wait_cyc(40);
    send_frame(30, 4, 1'b1);
    wait_cyc(40);
    chk(frame_ok(32'hC00, 16, 4), "R6 stored bytes up to buffer size", 0, 1);
    chk(mem[32'hC10 >> 2] == 32'hA5A5A5A5, "R6 nothing past buffer end",
        mem[32'hC10 >> 2], 32'hA5A5A5A5);
    chk(mem[(32'h140 >> 2) + 4] == 32'h00000010, "R6 count equals buffer size",
        mem[(32'h140 >> 2) + 4], 32'h10);
    chk(mem[(32'h140 >> 2) + 5] == 32'h00101913, "R7 truncated short crc status",
        mem[(32'h140 >> 2) + 5], 32'h00101913);
  endtask

  task automatic t_overrun();
    put_desc(32'h160, 32'hE00, 32'h0, 32'h80000000, 32'h0, 32'h01008000);
    reg_write(2'd1, 32'h1);
    dly = 8;
    reg_write(2'd2, 32'h160);
    reg_write(2'd3, 32'h80000000);
    wait_cyc(150);
    send_frame(70, 5, 1'b0);
    wait_cyc(300);
    chk(frame_ok(32'hE00, 4, 5), "R8 first word stored", 0, 1);
    chk(mem[(32'hE00 >> 2) + 1] == 32'hA5A5A5A5, "R8 lost word not written",
        mem[(32'hE00 >> 2) + 1], 32'hA5A5A5A5);
    chk(mem[(32'h160 >> 2) + 4] == 32'h00000004, "R8 count excludes lost bytes",
        mem[(32'h160 >> 2) + 4], 32'h4);
    chk(mem[(32'h160 >> 2) + 5] == 32'h01000303, "R8 overrun status",
        mem[(32'h160 >> 2) + 5], 32'h01000303);
    dly = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5A5A5;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 32'h0;
    rx_valid = 1'b0; rx_data = 8'h0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_gating();
    t_basic();
    t_chain_short();
    t_w1c();
    t_unowned_trunc();
    t_overrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule